// File: doc/BRIEF.md
# Multi-Client Word-Stream Transmit Framer

This block lets several application clients share a single outgoing 32-bit word stream. Each client offers words one at a time over a four-phase request/acknowledge port. Every word carries a two-bit framing tag, and with its first word the client also supplies the payload length of its message. The block grants the stream to one client and keeps that grant until the client's end-tagged word has been accepted downstream. Other clients wait for their turn under round-robin order.

For each granted message the block first emits three header words: an identifier word that carries a fixed protocol/flags pattern with the client's port index in the low byte, the client's own message sequence number, and the payload length. The client's payload words follow in order. Downstream is a valid/ready word interface. While ready is low, the granted client's acknowledge is held back, so backpressure passes straight through to the client.

Top module: `wordlink_framer`

## Requirements
- R1: While reset is held and in the first cycle after it, `cli_ack` is all zeros and `out_valid` is low.
- R2: The first word of every outgoing message is 0x45C032pp, where pp is the granted client's port index in bits 7:0. It carries tag 2'b01 (start).
- R3: The second outgoing word is the granted client's sequence number and the third is the `cli_len` value that was sampled at grant, zero-extended. Both carry tag 2'b10 (middle).
- R4: The client's payload words are forwarded unchanged and in order. A client word tagged 2'b11 (end) goes out tagged 2'b11. Every other payload word, including the client's 2'b01 first word, goes out tagged 2'b10.
- R5: A client's ack rises in the cycle after its word is accepted downstream (`out_valid` and `out_ready` both high at a clock edge). Ack falls in the cycle after the block samples that client's req low.
- R6: While `out_valid` is high and `out_ready` is low, `out_data`, `out_tag` and `out_valid` hold their values and no ack is raised.
- R7: Once a client is granted, no word from any other client is output and no other client's ack rises until the granted client's end word has completed its handshake.
- R8: When the stream is idle, the grant goes to the first requesting client found by searching upward from the port after the last granted one, wrapping around. After reset the search starts at port 0.
- R9: Each client has its own sequence number. It starts at 0 after reset and increases by one for each message that client completes. Messages from other clients do not change it.
- R10: While the stream is idle, a raised req whose tag is not 2'b01 (start) is ignored: no ack and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cli_req | input | N_CLIENTS | Per-client four-phase request |
| cli_tag | input | 2*N_CLIENTS | Per-client framing tag: 01 start, 10 middle, 11 end |
| cli_data | input | N_CLIENTS*DATA_W | Per-client payload word |
| cli_len | input | N_CLIENTS*LEN_W | Per-client payload length in words, valid with the start word |
| cli_ack | output | N_CLIENTS | Per-client four-phase acknowledge |
| out_valid | output | 1 | Downstream word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Downstream word |
| out_tag | output | 2 | Downstream framing tag |

## Verification
The bench has all four clients open messages in the same cycle, and then two clients whose ports lie on either side of the last grant. This targets the round-robin pointer. A design that restarts the search at port 0, or does not update the pointer at grant, would send the messages in the wrong order. Downstream stalls are inserted while header and payload words are in flight. A design that raised ack before acceptance, or let data change during a stall, would lose or duplicate words. The bench also sends back-to-back messages from one client after that client has already sent one, to expose a sequence counter that is shared, or that increments at grant instead of at completion. A non-start request offered while idle has to stay unacknowledged.

// File: rtl/wlf_pkg.sv
package wlf_pkg;

    typedef enum logic [1:0] {
        TAG_NONE = 2'b00,
        TAG_SOP  = 2'b01,
        TAG_MID  = 2'b10,
        TAG_EOP  = 2'b11
    } wlf_tag_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_ID,
        ST_HDR_SEQ,
        ST_HDR_LEN,
        ST_PAY,
        ST_ACKW
    } wlf_state_e;

endpackage

// File: rtl/wlf_rr_pick.sv
module wlf_rr_pick #(
    parameter int N_CLIENTS = 4,
    localparam int IDX_W = $clog2(N_CLIENTS)
) (
    input  logic [N_CLIENTS-1:0] req,
    input  logic [IDX_W-1:0]     last,
    output logic                 any,
    output logic [IDX_W-1:0]     pick
);

    // search upward from the port after the last grant, wrapping
    always_comb begin
        int idx;
        any  = 1'b0;
        pick = last;
        for (int off = 1; off <= N_CLIENTS; off++) begin
            idx = (int'(last) + off) % N_CLIENTS;
            if (!any && req[idx]) begin
                any  = 1'b1;
                pick = IDX_W'(idx);
            end
        end
    end

endmodule

// File: rtl/wlf_seq_bank.sv
module wlf_seq_bank #(
    parameter int N_CLIENTS = 4,
    parameter int SEQ_W     = 32,
    localparam int IDX_W = $clog2(N_CLIENTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic [IDX_W-1:0] sel,
    output logic [SEQ_W-1:0] seq_o
);

    logic [SEQ_W-1:0] cnt_d [N_CLIENTS];
    logic [SEQ_W-1:0] cnt_q [N_CLIENTS];

    for (genvar g = 0; g < N_CLIENTS; g++) begin : g_cnt
        always_comb begin
            cnt_d[g] = cnt_q[g];
            if (inc && sel == IDX_W'(g)) begin
                cnt_d[g] = cnt_q[g] + SEQ_W'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[g] <= '0;
            else        cnt_q[g] <= cnt_d[g];
        end
    end

    assign seq_o = cnt_q[sel];

endmodule

// File: rtl/wordlink_framer.sv
module wordlink_framer #(
    parameter int                N_CLIENTS = 4,
    parameter int                DATA_W    = 32,
    parameter int                LEN_W     = 16,
    parameter int                SEQ_W     = 32,
    parameter logic [DATA_W-1:0] HDR_ID    = 32'h45C0_3200,
    localparam int IDX_W = $clog2(N_CLIENTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_CLIENTS-1:0]          cli_req,
    input  logic [2*N_CLIENTS-1:0]        cli_tag,
    input  logic [N_CLIENTS*DATA_W-1:0]   cli_data,
    input  logic [N_CLIENTS*LEN_W-1:0]    cli_len,
    output logic [N_CLIENTS-1:0]          cli_ack,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [DATA_W-1:0]             out_data,
    output logic [1:0]                    out_tag
);
    import wlf_pkg::*;

    typedef struct packed {
        wlf_state_e           st;
        logic [IDX_W-1:0]     gnt;
        logic [IDX_W-1:0]     last;
        logic [LEN_W-1:0]     len;
        logic [N_CLIENTS-1:0] ack;
        logic                 fin;
    } ctl_t;

    ctl_t cr_q, cr_d;

    logic [N_CLIENTS-1:0] start_req;
    logic                 arb_any;
    logic [IDX_W-1:0]     arb_pick;
    logic                 seq_inc;
    logic [SEQ_W-1:0]     seq_cur;
    logic                 g_req;
    logic                 g_is_end;
    logic [DATA_W-1:0]    g_data;
    wlf_tag_e             tag_o;

    // only a start-tagged request can open a message
    for (genvar i = 0; i < N_CLIENTS; i++) begin : g_start
        assign start_req[i] = cli_req[i] && (cli_tag[2*i +: 2] == TAG_SOP);
    end

    wlf_rr_pick #(.N_CLIENTS(N_CLIENTS)) u_pick (
        .req  (start_req),
        .last (cr_q.last),
        .any  (arb_any),
        .pick (arb_pick)
    );

    wlf_seq_bank #(.N_CLIENTS(N_CLIENTS), .SEQ_W(SEQ_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (seq_inc),
        .sel   (cr_q.gnt),
        .seq_o (seq_cur)
    );

    assign g_req    = cli_req[cr_q.gnt];
    assign g_data   = cli_data[cr_q.gnt*DATA_W +: DATA_W];
    assign g_is_end = (cli_tag[cr_q.gnt*2 +: 2] == TAG_EOP);

    always_comb begin
        cr_d      = cr_q;
        out_valid = 1'b0;
        out_data  = '0;
        tag_o     = TAG_NONE;
        seq_inc   = 1'b0;
        unique case (cr_q.st)
            ST_IDLE: begin
                if (arb_any) begin
                    cr_d.gnt  = arb_pick;
                    cr_d.last = arb_pick;
                    cr_d.len  = cli_len[arb_pick*LEN_W +: LEN_W];
                    cr_d.st   = ST_HDR_ID;
                end
            end
            ST_HDR_ID: begin
                out_valid = 1'b1;
                out_data  = HDR_ID | DATA_W'(cr_q.gnt);
                tag_o     = TAG_SOP;
                if (out_ready) cr_d.st = ST_HDR_SEQ;
            end
            ST_HDR_SEQ: begin
                out_valid = 1'b1;
                out_data  = DATA_W'(seq_cur);
                tag_o     = TAG_MID;
                if (out_ready) cr_d.st = ST_HDR_LEN;
            end
            ST_HDR_LEN: begin
                out_valid = 1'b1;
                out_data  = DATA_W'(cr_q.len);
                tag_o     = TAG_MID;
                if (out_ready) cr_d.st = ST_PAY;
            end
            ST_PAY: begin
                if (g_req) begin
                    out_valid = 1'b1;
                    out_data  = g_data;
                    tag_o     = g_is_end ? TAG_EOP : TAG_MID;
                    if (out_ready) begin
                        cr_d.ack[cr_q.gnt] = 1'b1;
                        cr_d.fin           = g_is_end;
                        cr_d.st            = ST_ACKW;
                    end
                end
            end
            ST_ACKW: begin
                if (!g_req) begin
                    cr_d.ack = '0;
                    if (cr_q.fin) begin
                        seq_inc = 1'b1;
                        cr_d.st = ST_IDLE;
                    end else begin
                        cr_d.st = ST_PAY;
                    end
                end
            end
            default: cr_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q.st   <= ST_IDLE;
            cr_q.gnt  <= '0;
            cr_q.last <= IDX_W'(N_CLIENTS - 1);
            cr_q.len  <= '0;
            cr_q.ack  <= '0;
            cr_q.fin  <= 1'b0;
        end else begin
            cr_q <= cr_d;
        end
    end

    assign cli_ack = cr_q.ack;
    assign out_tag = tag_o;

endmodule

// File: rtl/wlf_chk.sv
module wlf_chk #(
    parameter int                N_CLIENTS = 4,
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] HDR_ID    = 32'h45C0_3200
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_CLIENTS-1:0] cli_req,
    input logic [N_CLIENTS-1:0] cli_ack,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [DATA_W-1:0]    out_data,
    input logic [1:0]           out_tag
);

    // R7
    ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cli_ack));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));

    // R2
    sop_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 2'b01) |-> (out_data[DATA_W-1:8] == HDR_ID[DATA_W-1:8]));

    for (genvar i = 0; i < N_CLIENTS; i++) begin : g_port
        // R5
        ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cli_ack[i]) |-> $past(out_valid && out_ready));

        // R5
        ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cli_ack[i]) |-> !$past(cli_req[i]));

        // R6
        no_ack_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_ready) |=> !$rose(cli_ack[i]));
    end

endmodule

bind wordlink_framer wlf_chk #(
    .N_CLIENTS (N_CLIENTS),
    .DATA_W    (DATA_W),
    .HDR_ID    (HDR_ID)
) u_wlf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cli_req   (cli_req),
    .cli_ack   (cli_ack),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_tag   (out_tag)
);

// File: tb/wordlink_framer_tb.sv
`timescale 1ns/1ps
module wordlink_framer_tb;

    localparam int NCL   = 4;
    localparam int DW    = 32;
    localparam int LW    = 16;
    localparam logic [1:0] T_SOP = 2'b01;
    localparam logic [1:0] T_MID = 2'b10;
    localparam logic [1:0] T_EOP = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCL-1:0]    cli_req = '0;
    logic [2*NCL-1:0]  cli_tag = '0;
    logic [NCL*DW-1:0] cli_data = '0;
    logic [NCL*LW-1:0] cli_len = '0;
    logic [NCL-1:0]    cli_ack;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [DW-1:0]     out_data;
    logic [1:0]        out_tag;

    int n_chk = 0;
    int n_fail = 0;
    int seq_m [NCL];
    logic [33:0] exp_q [NCL][$];
    int order_q [$];
    bit stall_mode = 1'b0;

    always #2 clk = ~clk;

    wordlink_framer u_dut (
        .clk(clk), .rst_n(rst_n), .cli_req(cli_req), .cli_tag(cli_tag),
        .cli_data(cli_data), .cli_len(cli_len), .cli_ack(cli_ack),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_tag(out_tag)
    );

    task automatic chk(input bit ok, input string rq, input logic [33:0] act, input logic [33:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // driver: pushes expected words, then runs the four-phase handshake per word
    task automatic send_msg(input int c, input int nw);
        exp_q[c].push_back({T_SOP, 32'h45C0_3200 | 32'(c)});
        exp_q[c].push_back({T_MID, 32'(seq_m[c])});
        exp_q[c].push_back({T_MID, 32'(nw)});
        for (int w = 0; w < nw; w++)
            exp_q[c].push_back({(w == nw-1) ? T_EOP : T_MID, 32'hC000_0000 | (c << 16) | w});
        seq_m[c]++;
        @(posedge clk); #1;
        cli_len[c*LW +: LW] = LW'(nw);
        for (int w = 0; w < nw; w++) begin
            cli_data[c*DW +: DW] = 32'hC000_0000 | (c << 16) | w;
            cli_tag[2*c +: 2]    = (w == 0) ? T_SOP : ((w == nw-1) ? T_EOP : T_MID);
            cli_req[c]           = 1'b1;
            forever begin
                @(posedge clk); #1;
                if (cli_ack[c]) break;
            end
            cli_req[c] = 1'b0;
            @(posedge clk); #1;
            // R5 ack drops one cycle after req seen low
            chk(cli_ack[c] == 1'b0, "R5 ack release", 34'(cli_ack), 34'(0));
        end
    endtask

    // monitor / scoreboard
    initial begin
        int cur = -1;
        int widx = 0;
        bit was_stall = 0;
        logic [33:0] prev_w = '0;
        logic [33:0] got, exp;
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
            #1;
            if (!rst_n) begin
                was_stall = 0;
                continue;
            end
            got = {out_tag, out_data};
            if (was_stall)
                // R6 word held through stall
                chk(out_valid && got == prev_w, "R6 hold", got, prev_w);
            was_stall = out_valid && !out_ready;
            prev_w = got;
            if (was_stall)
                chk(cli_ack == '0, "R6 no ack in stall", 34'(cli_ack), 34'(0));
            if (out_valid && out_ready) begin
                if (cur < 0) begin
                    int want;
                    want = (order_q.size() > 0) ? order_q.pop_front() : -1;
                    // R8 grant order, R2 start tag and port byte
                    chk(out_tag == T_SOP && int'(out_data[7:0]) == want, "R8 grant order", got, 34'(want));
                    cur = want;
                    widx = 0;
                end
                if (cur < 0 || exp_q[cur].size() == 0) begin
                    chk(1'b0, "R7 unexpected word", got, '0);
                end else begin
                    exp = exp_q[cur].pop_front();
                    // R2/R3 header, R4 payload, R7 no foreign words
                    chk(got == exp, (widx < 3) ? "R2 R3 header" : "R4 R7 payload", got, exp);
                end
                if (out_tag == T_EOP) cur = -1;
                widx++;
                if (widx > 3) begin
                    int p;
                    p = (cur < 0) ? int'(prev_w[7:0]) : cur;
                    @(posedge clk); #1;
                    if (cur >= 0)
                        // R5 ack one cycle after acceptance, R7 only the granted port
                        chk(cli_ack == NCL'(1 << cur), "R5 R7 ack rise", 34'(cli_ack), 34'(1 << cur));
                    else
                        chk($countones(cli_ack) == 1, "R5 R7 end ack", 34'(cli_ack), 34'(p));
                end
            end
        end
    end

    task automatic drain();
        int tries = 0;
        while ((exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size()) != 0 && tries < 1000) begin
            @(posedge clk);
            tries++;
        end
        chk(tries < 1000, "R4 drain", 34'(tries), 34'(0));
        repeat (4) @(posedge clk);
    endtask

    task automatic run_all();
        for (int i = 0; i < NCL; i++) seq_m[i] = 0;
        repeat (4) @(posedge clk);
        #3;
        // R1 during reset
        chk(cli_ack == '0 && !out_valid, "R1 in reset", {cli_ack, out_valid}, '0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(cli_ack == '0 && !out_valid, "R1 after reset", {cli_ack, out_valid}, '0);

        // S1 single client, search starts at port 0
        order_q.push_back(0);
        send_msg(0, 3);
        drain();

        // R10 non-start request while idle is ignored
        @(posedge clk); #1;
        cli_data[3*DW +: DW] = 32'hDEAD_BEEF;
        cli_tag[6 +: 2] = T_MID;
        cli_req[3] = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk); #1;
            chk(!cli_ack[3] && !out_valid, "R10 ignore", {cli_ack, out_valid}, '0);
        end
        cli_req[3] = 1'b0;
        cli_tag[6 +: 2] = 2'b00;

        // S2 all at once with stalls: last grant 0 so order 1,2,3,0
        stall_mode = 1'b1;
        order_q.push_back(1); order_q.push_back(2);
        order_q.push_back(3); order_q.push_back(0);
        fork
            send_msg(0, 2);
            send_msg(1, 4);
            send_msg(2, 3);
            send_msg(3, 5);
        join
        drain();

        // S3 ports 0 and 2 together, last grant 0 so 2 goes first (R8)
        order_q.push_back(2); order_q.push_back(0);
        fork
            send_msg(0, 2);
            send_msg(2, 2);
        join
        drain();

        // S4 R9 back-to-back from port 1: sequence 1 then 2
        stall_mode = 1'b0;
        order_q.push_back(1); order_q.push_back(1);
        send_msg(1, 2);
        send_msg(1, 3);
        drain();
        chk(order_q.size() == 0, "R8 all grants seen", 34'(order_q.size()), 34'(0));
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (60000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=complete");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule